// File: doc/BRIEF.md
# Four-Pin General Purpose I/O Port with Prioritised Alternate Functions

This block owns four package pins. Each pin is claimed by exactly one of four owners, picked by a fixed priority: a serial channel beats a timer output channel, which beats a PWM channel, which beats plain software-controlled GPIO. Software reaches the port through a small register bus. It holds a data register, a direction register and a read-only register that shows the pin levels.

Each peripheral arrives as per-pin enable and data inputs. The port chooses the pin's output value and output enable from the winning owner. Pin levels are brought in through a two-flop synchronizer. The synchronized levels feed both the register reads and the peripherals. A data register read returns the stored bit for pins set as outputs and the synchronized pin level for pins set as inputs. A timer capture on a pin only sees a clean external signal when that pin's direction bit is 0, so that GPIO is not driving it.

Top module: `gpio_altfn_port`

## Requirements
- R1: After a synchronous active-low reset, the data and direction registers are 0 and every pin left to GPIO has `pin_oe` low.
- R2: When `ser_en[i]` is 1 the serial channel owns pin i, whatever the other enables are. With `ser_tx[i]`=1 (transmit) the pin drives `ser_dout[i]` with `pin_oe[i]`=1. With `ser_tx[i]`=0 (receive) `pin_oe[i]`=0 and `pin_o[i]`=0.
- R3: When `ser_en[i]` is 0 and `tmr_en[i]` is 1, the pin drives `tmr_dout[i]` with `pin_oe[i]`=1, whatever `pwm_en[i]` is.
- R4: When `ser_en[i]` and `tmr_en[i]` are 0 and `pwm_en[i]` is 1, the pin drives `pwm_dout[i]` with `pin_oe[i]`=1.
- R5: With no peripheral enabled on pin i, `pin_o[i]` equals data register bit i and `pin_oe[i]` equals direction register bit i.
- R6: A read of the data register (offset 0x50) returns, in bits 3..0, data bit i where direction bit i is 1 and the synchronized pin level where it is 0. Bits 7..4 read 0.
- R7: A read of the input register (offset 0x51) returns the synchronized pin levels in bits 3..0 and 0 in bits 7..4, whatever the direction bits are.
- R8: A write to offset 0x51 changes neither the data register nor the direction register.
- R9: A pin level change shows up on `pin_sync` and in register reads after exactly two rising clock edges, and not after one.
- R10: The direction register is at offset 0x52 and reads back its bits in 3..0 with 0 in bits 7..4. Write data bits 7..4 are dropped for the data and direction registers.
- R11: The synchronizer is not reset, so the input register follows the pins while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ser_en | input | 4 | Serial function enable per pin |
| ser_tx | input | 4 | Serial role per pin: 1 transmit, 0 receive |
| ser_dout | input | 4 | Serial transmit data per pin |
| tmr_en | input | 4 | Timer output channel enable per pin |
| tmr_dout | input | 4 | Timer output level per pin |
| pwm_en | input | 4 | PWM channel enable per pin |
| pwm_dout | input | 4 | PWM output level per pin |
| pin_i | input | 4 | Raw pin levels from the pads |
| pin_o | output | 4 | Pin output levels to the pads |
| pin_oe | output | 4 | Pin output enables to the pads |
| pin_sync | output | 4 | Synchronized pin levels for the peripherals |

## Verification
The assertions assume the register bus has at most one write per cycle and that an address stays steady across the edge that takes its write. The bench keeps to this by changing address and strobe only on falling edges. The synchronizer latency check assumes `pin_i` has been driven since before reset was released. The bench drives the pins from time zero and holds reset for several cycles. The priority properties treat the peripheral inputs as settled at each rising edge, and the bench changes them only between edges.

// File: rtl/gpio_port_pkg.sv
// Package: shared types and owner selection for the GPIO port.
// Assumes: priority serial > timer > PWM > GPIO is fixed and not configurable.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_PWM  = 2'd1,
        OWN_TMR  = 2'd2,
        OWN_SER  = 2'd3
    } pin_owner_e;

    // Pick the owner of one pin from its three peripheral enables.
    function automatic pin_owner_e pick_owner(input logic ser, input logic tmr, input logic pwm);
        pin_owner_e who;
        if (ser)      who = OWN_SER;
        else if (tmr) who = OWN_TMR;
        else if (pwm) who = OWN_PWM;
        else          who = OWN_GPIO;
        return who;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
// Module: two-flop synchronizer for the pin inputs.
// Assumes: no reset on purpose, so the levels stay live while reset is held.
module gpio_port_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    // Two flop stages, with no reset term.
    always_ff @(posedge clk) begin
        meta_q <= d;
        hold_q <= meta_q;
    end

    assign q = hold_q;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(d, 2)); // R9

endmodule

// File: rtl/gpio_port_regs.sv
// Module: register file (data, direction, read-only input) and the read mux.
// Assumes: DW > PINS, one access per cycle, write taken on the rising edge.
module gpio_port_regs #(
    parameter int              PINS     = 4,
    parameter int              AW       = 8,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   DATA_OFS = 8'h50,
    parameter logic [AW-1:0]   IN_OFS   = 8'h51,
    parameter logic [AW-1:0]   DIR_OFS  = 8'h52
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_sync,
    output logic [PINS-1:0] data_q,
    output logic [PINS-1:0] dir_q
);

    localparam int          PAD = DW - PINS;
    localparam logic [DW-1:0] LOW_MASK = {{PAD{1'b0}}, {PINS{1'b1}}};

    logic [PINS-1:0] data_view;

    // Data register: cleared by reset, written at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data_q <= '0;
        else if (bus_wr && bus_addr == DATA_OFS) data_q <= bus_wdata[PINS-1:0];
    end

    // Direction register: cleared by reset, written at its own offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dir_q <= '0;
        else if (bus_wr && bus_addr == DIR_OFS) dir_q <= bus_wdata[PINS-1:0];
    end

    // Per-bit choice between stored value and live pin for data reads.
    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            data_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
        end
    end

    // Read mux; unknown offsets read as zero.
    always_comb begin
        case (bus_addr)
            DATA_OFS: bus_rdata = {{PAD{1'b0}}, data_view};
            IN_OFS:   bus_rdata = {{PAD{1'b0}}, pin_sync};
            DIR_OFS:  bus_rdata = {{PAD{1'b0}}, dir_q};
            default:  bus_rdata = '0;
        endcase
    end

    AST_INPUT_REG_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IN_OFS) |=> ($stable(data_q) && $stable(dir_q))); // R8

    AST_INPUT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == IN_OFS) |-> (bus_rdata[DW-1:PINS] == '0)); // R7

    AST_DIR_HIGH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_OFS) |=>
        ({{PAD{1'b0}}, dir_q} == ($past(bus_wdata) & LOW_MASK))); // R10

endmodule

// File: rtl/gpio_port_pinmux.sv
// Module: per-pin owner selection and output drive.
// Assumes: peripheral inputs are already synchronous to clk.
module gpio_port_pinmux
    import gpio_port_pkg::*;
#(
    parameter int PINS = 4
) (
    input  logic [PINS-1:0] ser_en,
    input  logic [PINS-1:0] ser_tx,
    input  logic [PINS-1:0] ser_dout,
    input  logic [PINS-1:0] tmr_en,
    input  logic [PINS-1:0] tmr_dout,
    input  logic [PINS-1:0] pwm_en,
    input  logic [PINS-1:0] pwm_dout,
    input  logic [PINS-1:0] data_q,
    input  logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] pin_o,
    output logic [PINS-1:0] pin_oe
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        pin_owner_e owner;

        // Decide who owns this pin.
        always_comb owner = pick_owner(ser_en[g], tmr_en[g], pwm_en[g]);

        // Drive level and enable from the owner.
        always_comb begin
            case (owner)
                OWN_SER: begin
                    pin_oe[g] = ser_tx[g];
                    pin_o[g]  = ser_tx[g] & ser_dout[g];
                end
                OWN_TMR: begin
                    pin_oe[g] = 1'b1;
                    pin_o[g]  = tmr_dout[g];
                end
                OWN_PWM: begin
                    pin_oe[g] = 1'b1;
                    pin_o[g]  = pwm_dout[g];
                end
                default: begin
                    pin_oe[g] = dir_q[g];
                    pin_o[g]  = data_q[g];
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio_altfn_port.sv
// Module: top of the four-pin port with prioritised alternate functions.
// Assumes: bus and peripheral inputs are synchronous to clk; pin_i is asynchronous.
module gpio_altfn_port #(
    parameter int PINS = 4,
    parameter int AW   = 8,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] ser_en,
    input  logic [PINS-1:0] ser_tx,
    input  logic [PINS-1:0] ser_dout,
    input  logic [PINS-1:0] tmr_en,
    input  logic [PINS-1:0] tmr_dout,
    input  logic [PINS-1:0] pwm_en,
    input  logic [PINS-1:0] pwm_dout,
    input  logic [PINS-1:0] pin_i,
    output logic [PINS-1:0] pin_o,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pin_sync
);

    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;

    gpio_port_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (pin_sync)
    );

    gpio_port_regs #(.PINS(PINS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    gpio_port_pinmux #(.PINS(PINS)) u_mux (
        .ser_en   (ser_en),
        .ser_tx   (ser_tx),
        .ser_dout (ser_dout),
        .tmr_en   (tmr_en),
        .tmr_dout (tmr_dout),
        .pwm_en   (pwm_en),
        .pwm_dout (pwm_dout),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_chk
        AST_SER_RX_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            (ser_en[g] && !ser_tx[g]) |-> !pin_oe[g]); // R2
        AST_TMR_OVER_PWM: assert property (@(posedge clk) disable iff (!rst_n)
            (!ser_en[g] && tmr_en[g]) |-> (pin_oe[g] && pin_o[g] == tmr_dout[g])); // R3
        AST_PWM_OVER_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
            (!ser_en[g] && !tmr_en[g] && pwm_en[g]) |-> (pin_oe[g] && pin_o[g] == pwm_dout[g])); // R4
        AST_GPIO_FOLLOWS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
            (!ser_en[g] && !tmr_en[g] && !pwm_en[g]) |-> (pin_oe[g] == dir_q[g] && pin_o[g] == data_q[g])); // R5
    end

endmodule

// File: tb/gpio_altfn_port_bench.sv
// Bench: directed tasks, one per scenario, each checking its own results.
module gpio_altfn_port_bench;

    localparam logic [7:0] A_DATA = 8'h50;
    localparam logic [7:0] A_IN   = 8'h51;
    localparam logic [7:0] A_DIR  = 8'h52;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] ser_en = '0, ser_tx = '0, ser_dout = '0;
    logic [3:0] tmr_en = '0, tmr_dout = '0;
    logic [3:0] pwm_en = '0, pwm_dout = '0;
    logic [3:0] pin_i = '0;
    logic [3:0] pin_o, pin_oe, pin_sync;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_altfn_port u_gpio_altfn_port (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_en(ser_en), .ser_tx(ser_tx), .ser_dout(ser_dout),
        .tmr_en(tmr_en), .tmr_dout(tmr_dout),
        .pwm_en(pwm_en), .pwm_dout(pwm_dout),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .pin_sync(pin_sync)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(negedge clk);
        pin_i = v;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        bus_read(A_DIR, r);  chk("R1 dir after reset", r, 8'h00);
        bus_read(A_DATA, r); chk("R1 data read after reset", r, 8'h00);
        chk("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
    endtask

    task automatic t_gpio_out();
        logic [3:0] d = 4'h6, m = 4'hC;
        bus_write(A_DATA, {4'h0, d});
        bus_write(A_DIR, {4'h0, m});
        @(negedge clk);
        chk("R5 gpio oe", {4'h0, pin_oe}, {4'h0, m});
        chk("R5 gpio out", {4'h0, pin_o}, {4'h0, d});
    endtask

    task automatic t_read_mux();
        logic [7:0] r;
        logic [3:0] d = 4'h6, m = 4'hC, p = 4'h9;
        set_pins(p);
        bus_read(A_DATA, r);
        chk("R6 data read mix", r, {4'h0, (d & m) | (p & ~m)});
        bus_read(A_IN, r);
        chk("R7 input reg", r, {4'h0, p});
        chk("R9 pin_sync", {4'h0, pin_sync}, {4'h0, p});
    endtask

    task automatic t_write_input_ignored();
        logic [7:0] r;
        bus_write(A_DIR, 8'h0F);
        bus_write(A_IN, 8'hFF);
        bus_read(A_DATA, r); chk("R8 data kept", r, 8'h06);
        bus_read(A_DIR, r);  chk("R8 dir kept", r, 8'h0F);
        bus_read(A_IN, r);   chk("R7 input ignores dir", r, 8'h09);
    endtask

    task automatic t_high_bits();
        logic [7:0] r;
        bus_write(A_DIR, 8'hF3);
        bus_read(A_DIR, r);  chk("R10 dir high bits dropped", r, 8'h03);
        bus_write(A_DATA, 8'hA5);
        bus_read(A_DATA, r); chk("R10 data high bits dropped", r, {4'h0, (4'h5 & 4'h3) | (4'h9 & 4'hC)});
    endtask

    task automatic t_priority();
        @(negedge clk);
        bus_addr = 8'h00;
        ser_en = 4'b0011; ser_tx = 4'b0001; ser_dout = 4'b0011;
        tmr_en = 4'b0110; tmr_dout = 4'b0100;
        pwm_en = 4'b1110; pwm_dout = 4'b1010;
        #2;
        chk("R2 serial tx/rx oe", {7'h0, pin_oe[0]} | {6'h0, pin_oe[1], 1'b0}, 8'h01);
        chk("R2 serial tx/rx out", {6'h0, pin_o[1:0]}, 8'h01);
        chk("R3 timer over pwm", {7'h0, pin_o[2]} | {6'h0, pin_oe[2], 1'b0}, 8'h03);
        chk("R4 pwm over gpio", {7'h0, pin_o[3]} | {6'h0, pin_oe[3], 1'b0}, 8'h03);
        @(negedge clk);
        tmr_dout = 4'b0000; pwm_dout = 4'b0000; ser_dout = 4'b0000;
        #2;
        chk("R3 timer level follows", {7'h0, pin_o[2]}, 8'h00);
        chk("R4 pwm level follows", {7'h0, pin_o[3]}, 8'h00);
        @(negedge clk);
        ser_en = '0; ser_tx = '0; tmr_en = '0; pwm_en = '0;
    endtask

    task automatic t_sync_latency();
        logic [7:0] r;
        @(negedge clk);
        pin_i = 4'h6;
        @(posedge clk);
        @(negedge clk);
        bus_addr = A_IN; #2 r = bus_rdata;
        chk("R9 not after one edge", r, 8'h09);
        @(posedge clk);
        @(negedge clk);
        #2 r = bus_rdata;
        chk("R9 after two edges", r, 8'h06);
    endtask

    task automatic t_reset_live();
        logic [7:0] r;
        @(negedge clk);
        rst_n = 1'b0;
        set_pins(4'hA);
        bus_read(A_IN, r);   chk("R11 input live in reset", r, 8'h0A);
        bus_read(A_DATA, r); chk("R1 data read shows pins in reset", r, 8'h0A);
        chk("R1 oe low in reset", {4'h0, pin_oe}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpio_out();
        t_read_mux();
        t_write_input_ignored();
        t_high_bits();
        t_priority();
        t_sync_latency();
        t_reset_live();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule